// File: doc/BRIEF.md
# Carry Increment Adder

A purely combinational two-operand adder built from fixed-size bit groups. The lowest group is an ordinary ripple chain of full adders. Every group above it adds its own operand slice with a carry-in of zero. It then corrects that provisional result with a chain of half adders that increments the slice when the carry arriving from the group below is set. The carry leaving each higher group is taken from the provisional chain's carry out, or from the half-adder chain's carry out gated by the AND of the slice's propagate terms.

Each operand can have its own width. The narrower one is widened to the common width N, and the sum comes out one bit wider than N. A parameter selects unsigned or two's-complement arithmetic. This choice decides how the narrower operand is widened and how the extra top bit of the result is formed. The block sits inside larger datapaths wherever a ripple chain is too slow but a carry-select adder costs too much area.

Top module: `cia_adder`

## Requirements
- R1: The low N bits of `s` equal (widened `a` + widened `b`) modulo 2^N, where N is the larger of the two operand widths.
- R2: With SIGNED = 0, `s[N]` is the carry out of the N-bit addition, so `s` equals the full unsigned sum of the zero-widened operands.
- R3: With SIGNED = 1, `s[N]` equals the XOR of both widened sign bits with the final carry, so `s` read as an (N+1)-bit two's-complement value equals the exact signed sum.
- R4: When A_W and B_W differ, the narrower operand is widened before addition: with zeros when SIGNED = 0, and by copying its top bit when SIGNED = 1.
- R5: GROUP must be at least 1, or elaboration stops. When N is not a multiple of GROUP, the topmost group covers only the leftover bits, and the result is still exact.
- R6: The carry leaving every group equals the carry that the true sum produces at that bit position. A carry therefore passes through every group when one operand is all ones and the other is 1.
- R7: The result does not depend on the grouping: GROUP = 1 and GROUP = N give the same sums as any other group size.
- R8: The block holds no state. `s` follows a change on `a` or `b` without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_W | First operand |
| b | input | B_W | Second operand |
| s | output | N+1 | Sum, N = max(A_W, B_W) |

## Verification
The hardest case to reach is a carry that enters a higher group and has to pass through its increment chain. That happens only when the provisional slice sum is all ones and no carry was generated inside the slice. With random operands this is rare, and rarer still when several groups must do it in a row. Small widths are therefore swept over every operand pair for group sizes 1, 2, 4 and 5 in both arithmetic modes, which reaches every carry pattern at every group boundary, including the short top group. At 16 and 32 bits, directed operands (all ones plus one, all ones plus all ones, the extreme signed values) force a carry through every group, and random operands fill in the rest.

// File: rtl/cia_pkg.sv
package cia_pkg;

   // larger of two widths
   function automatic int unsigned cia_max(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

   // number of groups needed to cover n bits with groups of gs bits
   function automatic int unsigned cia_groups(input int unsigned n, input int unsigned gs);
      return (gs == 0) ? 1 : (n + gs - 1) / gs;
   endfunction

   // width of group idx: full size, or the remainder for the top group
   function automatic int unsigned cia_grp_w(input int unsigned n, input int unsigned gs,
                                             input int unsigned idx);
      int unsigned rem;
      rem = n - idx * gs;
      return (rem < gs) ? rem : gs;
   endfunction

endpackage

// File: rtl/cia_fa_bit.sv
module cia_fa_bit (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic hx;
   assign hx = x ^ y;
   assign s  = hx ^ ci;
   assign co = (x & y) | (hx & ci);
endmodule

// File: rtl/cia_extend.sv
module cia_extend #(
   parameter int unsigned IN_W   = 4,
   parameter int unsigned OUT_W  = 8,
   parameter bit          SIGNED = 1'b0
) (
   input  logic [IN_W-1:0]  x,
   output logic [OUT_W-1:0] y
);
   localparam int unsigned PAD = OUT_W - IN_W;

   if (OUT_W < IN_W) begin : g_bad_w
      $error("cia_extend: OUT_W must not be below IN_W");
   end

   if (PAD == 0) begin : g_same
      assign y = x;
   end else if (SIGNED) begin : g_sext
      assign y = {{PAD{x[IN_W-1]}}, x};
   end else begin : g_zext
      assign y = {{PAD{1'b0}}, x};
   end
endmodule

// File: rtl/cia_base_group.sv
module cia_base_group #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] rc;

   assign rc[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_bit
      cia_fa_bit u_fa (
         .x  (x[i]),
         .y  (y[i]),
         .ci (rc[i]),
         .s  (sum[i]),
         .co (rc[i+1])
      );
   end

   assign cout = rc[W];
endmodule

// File: rtl/cia_incr_group.sv
module cia_incr_group #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0]   zc;     // carries of the zero-carry-in chain
   logic [W-1:0] psum;   // provisional sum
   logic [W-1:0] prop;   // per-bit propagate
   logic [W:0]   hc;     // carries of the increment chain

   assign zc[0] = 1'b0;
   assign hc[0] = cin;
   assign prop  = x ^ y;

   for (genvar i = 0; i < W; i++) begin : g_bit
      cia_fa_bit u_fa (
         .x  (x[i]),
         .y  (y[i]),
         .ci (zc[i]),
         .s  (psum[i]),
         .co (zc[i+1])
      );
      // half adder of the increment chain
      assign sum[i]  = psum[i] ^ hc[i];
      assign hc[i+1] = psum[i] & hc[i];
   end

   assign cout = ((&prop) & hc[W]) | zc[W];
endmodule

// File: rtl/cia_adder.sv
module cia_adder
   import cia_pkg::*;
#(
   parameter int unsigned A_W    = 8,
   parameter int unsigned B_W    = 8,
   parameter int unsigned GROUP  = 4,
   parameter bit          SIGNED = 1'b0,
   localparam int unsigned N     = cia_max(A_W, B_W)
) (
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   output logic [N:0]     s
);
   localparam int unsigned NG = cia_groups(N, GROUP);

   // elaboration-time parameter checks (R5)
   if (GROUP < 1) begin : g_bad_group
      $error("cia_adder: GROUP must be at least 1");
   end
   if (A_W < 1 || B_W < 1) begin : g_bad_width
      $error("cia_adder: operand widths must be at least 1");
   end

   logic [N-1:0] a_ext;
   logic [N-1:0] b_ext;
   logic [N-1:0] s_low;
   logic [NG:0]  gc;       // gc[g] is the carry entering group g

   cia_extend #(.IN_W(A_W), .OUT_W(N), .SIGNED(SIGNED)) u_ext_a (.x(a), .y(a_ext));
   cia_extend #(.IN_W(B_W), .OUT_W(N), .SIGNED(SIGNED)) u_ext_b (.x(b), .y(b_ext));

   assign gc[0] = 1'b0;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      localparam int unsigned LO = g * GROUP;
      localparam int unsigned W  = cia_grp_w(N, GROUP, g);
      if (g == 0) begin : g_base
         cia_base_group #(.W(W)) u_grp (
            .x    (a_ext[LO +: W]),
            .y    (b_ext[LO +: W]),
            .cin  (gc[g]),
            .sum  (s_low[LO +: W]),
            .cout (gc[g+1])
         );
      end else begin : g_incr
         cia_incr_group #(.W(W)) u_grp (
            .x    (a_ext[LO +: W]),
            .y    (b_ext[LO +: W]),
            .cin  (gc[g]),
            .sum  (s_low[LO +: W]),
            .cout (gc[g+1])
         );
      end
   end

   if (SIGNED) begin : g_top_signed
      assign s = {a_ext[N-1] ^ b_ext[N-1] ^ gc[NG], s_low};
   end else begin : g_top_unsigned
      assign s = {gc[NG], s_low};
   end
endmodule

// File: rtl/cia_adder_chk.sv
module cia_adder_chk #(
   parameter int unsigned A_W    = 8,
   parameter int unsigned B_W    = 8,
   parameter int unsigned N      = 8,
   parameter int unsigned GROUP  = 4,
   parameter int unsigned NG     = 2,
   parameter bit          SIGNED = 1'b0
) (
   input logic [A_W-1:0] a,
   input logic [B_W-1:0] b,
   input logic [N-1:0]   a_ext,
   input logic [N-1:0]   b_ext,
   input logic [N:0]     s,
   input logic [NG:0]    gc
);
   logic known;
   assign known = !$isunknown({a, b, a_ext, b_ext, s, gc});

   // R1
   always_comb begin : c_low
      if (known) begin
         low_sum_chk: assert (s[N-1:0] == a_ext + b_ext)
            else $error("low sum mismatch");
      end
   end

   // R4
   always_comb begin : c_ext
      if (known) begin
         if (SIGNED) begin
            ext_a_chk: assert ($signed(a_ext) == N'($signed(a)))
               else $error("a widening wrong");
            ext_b_chk: assert ($signed(b_ext) == N'($signed(b)))
               else $error("b widening wrong");
         end else begin
            ext_a_chk_u: assert (a_ext == N'(a))
               else $error("a widening wrong");
            ext_b_chk_u: assert (b_ext == N'(b))
               else $error("b widening wrong");
         end
      end
   end

   // R2, R3
   always_comb begin : c_top
      if (known) begin
         if (SIGNED) begin
            signed_top_chk: assert ($signed(s) ==
                                    $signed({a_ext[N-1], a_ext}) + $signed({b_ext[N-1], b_ext}))
               else $error("signed result wrong");
         end else begin
            unsigned_top_chk: assert (s == {1'b0, a_ext} + {1'b0, b_ext})
               else $error("unsigned result wrong");
         end
      end
   end

   // R6: each group's carry out matches the true slice carry
   for (genvar g = 0; g < NG; g++) begin : g_gc
      localparam int unsigned LO = g * GROUP;
      localparam int unsigned W  = ((N - LO) < GROUP) ? (N - LO) : GROUP;
      always_comb begin : c_gc
         logic [W:0] t;
         t = {1'b0, a_ext[LO +: W]} + {1'b0, b_ext[LO +: W]} + {{W{1'b0}}, gc[g]};
         if (known) begin
            // R6
            group_carry_chk: assert (t[W] == gc[g+1])
               else $error("group carry wrong");
         end
      end
   end
endmodule

bind cia_adder cia_adder_chk #(
   .A_W(A_W), .B_W(B_W), .N(N), .GROUP(GROUP), .NG(NG), .SIGNED(SIGNED)
) u_chk (
   .a(a), .b(b), .a_ext(a_ext), .b_ext(b_ext), .s(s), .gc(gc)
);

// File: tb/test_cia_adder.sv
module test_cia_adder;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WD_LIMIT   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   // small sweep configurations: k<4 unsigned, k>=4 signed; group 1,2,4,5
   logic [4:0] a5, b5;
   logic [5:0] s5 [8];
   for (genvar k = 0; k < 8; k++) begin : g_n5
      localparam int unsigned GS = (k % 4 == 0) ? 1 : (k % 4 == 1) ? 2 : (k % 4 == 2) ? 4 : 5;
      cia_adder #(.A_W(5), .B_W(5), .GROUP(GS), .SIGNED(k >= 4)) i_cia_adder (
         .a(a5), .b(b5), .s(s5[k]));
   end

   // mixed widths
   logic [4:0] am;
   logic [2:0] bm;
   logic [5:0] smu, sms;
   cia_adder #(.A_W(5), .B_W(3), .GROUP(2), .SIGNED(1'b0)) i_cia_mix_u (.a(am), .b(bm), .s(smu));
   cia_adder #(.A_W(5), .B_W(3), .GROUP(2), .SIGNED(1'b1)) i_cia_mix_s (.a(am), .b(bm), .s(sms));

   // wide configurations
   logic [15:0] a16, b16;
   logic [16:0] s16u, s16s;
   logic [31:0] a32, b32;
   logic [32:0] s32u, s32s;
   cia_adder #(.A_W(16), .B_W(16), .GROUP(4), .SIGNED(1'b0)) i_cia_w16u (.a(a16), .b(b16), .s(s16u));
   cia_adder #(.A_W(16), .B_W(16), .GROUP(4), .SIGNED(1'b1)) i_cia_w16s (.a(a16), .b(b16), .s(s16s));
   cia_adder #(.A_W(32), .B_W(32), .GROUP(3), .SIGNED(1'b0)) i_cia_w32u (.a(a32), .b(b32), .s(s32u));
   cia_adder #(.A_W(32), .B_W(32), .GROUP(3), .SIGNED(1'b1)) i_cia_w32s (.a(a32), .b(b32), .s(s32s));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_LIMIT) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
         finish_run();
      end
   end

   task automatic check_wide(input string req);
      logic [16:0] e16u, e16s;
      logic [32:0] e32u, e32s;
      e16u = {1'b0, a16} + {1'b0, b16};
      e16s = {a16[15], a16} + {b16[15], b16};
      e32u = {1'b0, a32} + {1'b0, b32};
      e32s = {a32[31], a32} + {b32[31], b32};
      check({req, " R2 w16"}, 64'(s16u), 64'(e16u));
      check({req, " R3 w16"}, 64'(s16s), 64'(e16s));
      check({req, " R2 w32"}, 64'(s32u), 64'(e32u));
      check({req, " R3 w32"}, 64'(s32s), 64'(e32s));
   endtask

   initial begin
      a5 = '0; b5 = '0; am = '0; bm = '0;
      a16 = '0; b16 = '0; a32 = '0; b32 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: zero operands give zero everywhere
      for (int k = 0; k < 8; k++) check("R1 zero", 64'(s5[k]), 64'd0);
      check_wide("R1 zero");

      // exhaustive N=5 sweep: R1 R2 R3 R5 R7
      for (int i = 0; i < 32; i++) begin
         for (int j = 0; j < 32; j++) begin
            @(posedge clk);
            a5 = 5'(i); b5 = 5'(j);
            @(negedge clk);
            for (int k = 0; k < 8; k++) begin
               logic [5:0] e;
               if (k >= 4) e = {a5[4], a5} + {b5[4], b5};
               else        e = {1'b0, a5} + {1'b0, b5};
               check(k >= 4 ? "R3 R5 R7 sweep5" : "R2 R5 R7 sweep5", 64'(s5[k]), 64'(e));
            end
         end
      end

      // R8: output follows input with no clock edge
      a5 = 5'd3; b5 = 5'd4;
      #1;
      check("R8 no clock", 64'(s5[1]), 64'd7);

      // mixed-width sweep: R4
      for (int i = 0; i < 32; i++) begin
         for (int j = 0; j < 8; j++) begin
            logic [5:0] eu, es;
            @(posedge clk);
            am = 5'(i); bm = 3'(j);
            @(negedge clk);
            eu = {1'b0, am} + {3'b000, bm};
            es = {am[4], am} + {{3{bm[2]}}, bm};
            check("R4 zero widen", 64'(smu), 64'(eu));
            check("R4 sign widen", 64'(sms), 64'(es));
         end
      end

      // R6: carry through every group, and extreme values
      @(posedge clk); a16 = '1; b16 = 16'd1; a32 = '1; b32 = 32'd1;
      @(negedge clk); check_wide("R6 ripple all groups");
      check("R6 w32 carry", 64'(s32u), 64'h1_0000_0000);
      @(posedge clk); a16 = '1; b16 = '1; a32 = '1; b32 = '1;
      @(negedge clk); check_wide("R6 all ones");
      @(posedge clk); a16 = 16'h7fff; b16 = 16'h7fff; a32 = 32'h7fff_ffff; b32 = 32'h7fff_ffff;
      @(negedge clk); check_wide("R3 max pos");
      check("R3 w32 max pos", 64'(s32s), 64'h0_ffff_fffe);
      @(posedge clk); a16 = 16'h8000; b16 = 16'h8000; a32 = 32'h8000_0000; b32 = 32'h8000_0000;
      @(negedge clk); check_wide("R3 min neg");
      check("R3 w32 min neg", 64'(s32s), 64'h1_0000_0000);

      // random wide vectors: R1 R2 R3
      for (int r = 0; r < 3000; r++) begin
         @(posedge clk);
         a16 = 16'($urandom); b16 = 16'($urandom);
         a32 = $urandom; b32 = $urandom;
         @(negedge clk);
         check_wide("R1 random");
      end

      finish_run();
   end
endmodule